// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a 32-bit physical address using a small table of programmable block mappings. Two independent tables are kept, one for instruction fetches and one for data accesses, and a lookup selects one of them through an access-type input. Each table has four entries. All four entries of the selected table are compared with the address in the same cycle. A block can be any power-of-two size from 128 KB to 256 MB.

The unit also receives the result of an external page-translation lookup for the same access, as a hit flag, a physical address and attribute bits. It merges that result with its own. When a block entry matches, the block result is used even if the page lookup also hits. When nothing hits, a miss is flagged. Entries are loaded through a registered write port. The lookup path from address to result is purely combinational.

Top module: `bat_xlate_unit`

## Requirements
- R1: While `rst` is high on a clock edge, every entry in both tables is cleared to invalid. After reset, a lookup with `pg_hit` low gives `miss`=1, `hit`=0, `pa`=0, `src`=0 and `attr`=0.
- R2: A write presented on a clock edge (`wr_en`=1) is used by lookups from that edge on. On a block match, `pa[16:0]` equals `ea[16:0]`.
- R3: An entry's 11-bit length mask enables pass-through of `ea[27:17]`, with mask bit i controlling address bit 17+i. Address bits [31:17] that are not enabled are compared with the entry's effective base `wr_ebase` (which holds address bits [31:17]) and are taken from the physical base. Mask 0 gives a 128 KB block and mask 11'h7FF gives a 256 MB block.
- R4: An entry matches only when its valid bit for the current mode is set: `wr_vs` applies when `lk_super`=1 and `wr_vu` applies when `lk_super`=0.
- R5: `wr_side`/`lk_is_data` = 0 select the instruction table and 1 selects the data table. A lookup never matches an entry of the other table.
- R6: When several entries of the selected table match, the lowest-numbered entry supplies `pa` and `attr`.
- R7: When a block entry matches, `hit`=1, `src`=2'b01 (block), and `pa` and `attr` come from the block, whatever `pg_hit` is.
- R8: With no block match and `pg_hit`=1, `hit`=1, `src`=2'b10 (page), `pa`=`pg_pa` and `attr`=`pg_attr`.
- R9: With no block match and `pg_hit`=0, `miss`=1, `hit`=0, `src`=2'b00, and `pa` and `attr` are zero.
- R10: On a block match, `attr` is the matching entry's stored bits: [2] write-through, [1] cache-inhibit, [0] guarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Table to write: 0 instruction, 1 data |
| wr_idx | input | 2 | Entry number to write |
| wr_ebase | input | 15 | Effective base, address bits [31:17] |
| wr_pbase | input | 15 | Physical base, address bits [31:17] |
| wr_mask | input | 11 | Block length mask |
| wr_vs | input | 1 | Entry valid in supervisor mode |
| wr_vu | input | 1 | Entry valid in user mode |
| wr_attr | input | 3 | Attribute bits {write-through, cache-inhibit, guarded} |
| lk_ea | input | 32 | Effective address to translate |
| lk_is_data | input | 1 | Access type: 0 instruction, 1 data |
| lk_super | input | 1 | 1 supervisor, 0 user |
| pg_hit | input | 1 | Page-translation hit |
| pg_pa | input | 32 | Page-translation physical address |
| pg_attr | input | 3 | Page-translation attribute bits |
| pa | output | 32 | Physical address |
| hit | output | 1 | Translation found |
| miss | output | 1 | No translation found |
| src | output | 2 | Result source: 00 none, 01 block, 10 page |
| attr | output | 3 | Attribute bits of the result |

## Verification
Entry state can only be observed through lookups. A corrupted base, mask or valid bit shows up as a wrong `pa`, a missing hit or a page-sourced result on the first lookup that touches that entry, in the same cycle. Because the lookup is combinational, faults in the priority order or the table select show up in the lookup cycle itself. The directed scenarios therefore place overlapping entries, mode-restricted entries and addresses from the other table, and check `pa`, `src` and `attr` together on every lookup.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int BAT_ADDR_W = 32;
  localparam int BAT_OFS_W  = 17;
  localparam int BAT_MASK_W = 11;
  localparam int BAT_TAG_W  = BAT_ADDR_W - BAT_OFS_W;
  localparam int BAT_ATTR_W = 3;

  typedef struct packed {
    logic [BAT_TAG_W-1:0]  ebase;
    logic [BAT_TAG_W-1:0]  pbase;
    logic [BAT_MASK_W-1:0] mask;
    logic                  vs;
    logic                  vu;
    logic [BAT_ATTR_W-1:0] attr;
  } bat_entry_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_BLOCK = 2'b01,
    SRC_PAGE  = 2'b10
  } xlate_src_e;
endpackage

// File: rtl/bat_entry_bank.sv
module bat_entry_bank
  import bat_pkg::*;
#(
  parameter int NENT  = 4,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  bat_entry_t             wdata,
  output bat_entry_t [NENT-1:0]  ents
);
  bat_entry_t [NENT-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) begin
        store_q[i] <= '0;
      end
    end else if (we) begin
      store_q[widx] <= wdata;
    end
  end

  assign ents = store_q;

  logic [NENT-1:0] any_valid;
  always_comb begin
    for (int i = 0; i < NENT; i++) any_valid[i] = store_q[i].vs | store_q[i].vu;
  end

  // Reset leaves no entry valid in either mode
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (any_valid == '0));
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
(
  input  bat_entry_t             ent,
  input  logic [BAT_ADDR_W-1:0]  ea,
  input  logic                   super_mode,
  output logic                   match,
  output logic [BAT_ADDR_W-1:0]  pa
);
  localparam int PAD_W = BAT_TAG_W - BAT_MASK_W;

  logic [BAT_TAG_W-1:0] pass_m;
  logic [BAT_TAG_W-1:0] ea_tag;
  logic                 mode_ok;

  assign pass_m  = {{PAD_W{1'b0}}, ent.mask};
  assign ea_tag  = ea[BAT_ADDR_W-1:BAT_OFS_W];
  assign mode_ok = super_mode ? ent.vs : ent.vu;
  assign match   = mode_ok && (((ea_tag ^ ent.ebase) & ~pass_m) == '0);
  assign pa      = {(ent.pbase & ~pass_m) | (ea_tag & pass_m), ea[BAT_OFS_W-1:0]};
endmodule

// File: rtl/bat_pick.sv
module bat_pick
  import bat_pkg::*;
#(
  parameter int NENT = 4
) (
  input  logic [NENT-1:0]                        mvec,
  input  logic [NENT-1:0][BAT_ADDR_W-1:0]        pavec,
  input  logic [NENT-1:0][BAT_ATTR_W-1:0]        attrvec,
  output logic                                   any_hit,
  output logic [BAT_ADDR_W-1:0]                  sel_pa,
  output logic [BAT_ATTR_W-1:0]                  sel_attr
);
  always_comb begin
    any_hit  = |mvec;
    sel_pa   = '0;
    sel_attr = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (mvec[i]) begin
        sel_pa   = pavec[i];
        sel_attr = attrvec[i];
      end
    end
  end

  // Entry 0 always wins when it matches
  always_comb begin
    if (mvec[0]) assert_lowest_wins_R6: assert (sel_pa == pavec[0] && sel_attr == attrvec[0]);
  end
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
  import bat_pkg::*;
#(
  parameter int NENT  = 4,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int NSIDE = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_side,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [BAT_TAG_W-1:0]   wr_ebase,
  input  logic [BAT_TAG_W-1:0]   wr_pbase,
  input  logic [BAT_MASK_W-1:0]  wr_mask,
  input  logic                   wr_vs,
  input  logic                   wr_vu,
  input  logic [BAT_ATTR_W-1:0]  wr_attr,
  input  logic [BAT_ADDR_W-1:0]  lk_ea,
  input  logic                   lk_is_data,
  input  logic                   lk_super,
  input  logic                   pg_hit,
  input  logic [BAT_ADDR_W-1:0]  pg_pa,
  input  logic [BAT_ATTR_W-1:0]  pg_attr,
  output logic [BAT_ADDR_W-1:0]  pa,
  output logic                   hit,
  output logic                   miss,
  output logic [1:0]             src,
  output logic [BAT_ATTR_W-1:0]  attr
);
  bat_entry_t wdata;
  assign wdata = '{ebase: wr_ebase, pbase: wr_pbase, mask: wr_mask,
                   vs: wr_vs, vu: wr_vu, attr: wr_attr};

  logic [NSIDE-1:0]                  side_hit;
  logic [NSIDE-1:0][BAT_ADDR_W-1:0]  side_pa;
  logic [NSIDE-1:0][BAT_ATTR_W-1:0]  side_attr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    bat_entry_t [NENT-1:0]             ents;
    logic [NENT-1:0]                   mvec;
    logic [NENT-1:0][BAT_ADDR_W-1:0]   pavec;
    logic [NENT-1:0][BAT_ATTR_W-1:0]   attrvec;

    bat_entry_bank #(.NENT(NENT)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_en && (wr_side == s[0])),
      .widx(wr_idx), .wdata(wdata), .ents(ents)
    );

    for (genvar e = 0; e < NENT; e++) begin : g_ent
      bat_match u_match (
        .ent(ents[e]), .ea(lk_ea), .super_mode(lk_super),
        .match(mvec[e]), .pa(pavec[e])
      );
      assign attrvec[e] = ents[e].attr;
    end

    bat_pick #(.NENT(NENT)) u_pick (
      .mvec(mvec), .pavec(pavec), .attrvec(attrvec),
      .any_hit(side_hit[s]), .sel_pa(side_pa[s]), .sel_attr(side_attr[s])
    );
  end

  logic                  blk_hit;
  logic [BAT_ADDR_W-1:0] blk_pa;
  logic [BAT_ATTR_W-1:0] blk_attr;

  assign blk_hit  = side_hit[lk_is_data];
  assign blk_pa   = side_pa[lk_is_data];
  assign blk_attr = side_attr[lk_is_data];

  xlate_src_e src_sel;

  always_comb begin
    if (blk_hit) begin
      src_sel = SRC_BLOCK;
      pa      = blk_pa;
      attr    = blk_attr;
    end else if (pg_hit) begin
      src_sel = SRC_PAGE;
      pa      = pg_pa;
      attr    = pg_attr;
    end else begin
      src_sel = SRC_NONE;
      pa      = '0;
      attr    = '0;
    end
  end

  assign src  = src_sel;
  assign hit  = (src_sel != SRC_NONE);
  assign miss = ~hit;

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
    miss |-> (pa == '0 && attr == '0 && !pg_hit));
  assert_block_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (blk_hit && pg_hit) |-> (src == SRC_BLOCK && pa == blk_pa));
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_BLOCK) |-> (pa[BAT_OFS_W-1:0] == lk_ea[BAT_OFS_W-1:0]));
  assert_page_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (!blk_hit && pg_hit) |-> (pa == pg_pa && attr == pg_attr));
  assert_src_legal_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src) && (hit != miss));
endmodule

// File: tb/bat_xlate_unit_test.sv
module bat_xlate_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_side = 0, wr_vs = 0, wr_vu = 0;
  logic [1:0]  wr_idx = 0;
  logic [14:0] wr_ebase = 0, wr_pbase = 0;
  logic [10:0] wr_mask = 0;
  logic [2:0]  wr_attr = 0, pg_attr = 0;
  logic [31:0] lk_ea = 0, pg_pa = 0;
  logic lk_is_data = 0, lk_super = 0, pg_hit = 0;
  logic [31:0] pa;
  logic hit, miss;
  logic [1:0] src;
  logic [2:0] attr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bat_xlate_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
    .wr_ebase(wr_ebase), .wr_pbase(wr_pbase), .wr_mask(wr_mask), .wr_vs(wr_vs),
    .wr_vu(wr_vu), .wr_attr(wr_attr), .lk_ea(lk_ea), .lk_is_data(lk_is_data),
    .lk_super(lk_super), .pg_hit(pg_hit), .pg_pa(pg_pa), .pg_attr(pg_attr),
    .pa(pa), .hit(hit), .miss(miss), .src(src), .attr(attr)
  );

  task automatic put(input logic side, input logic [1:0] idx, input logic [31:0] ebase_addr,
                     input logic [31:0] pbase_addr, input logic [10:0] m,
                     input logic vs, input logic vu, input logic [2:0] at);
    @(negedge clk);
    wr_en = 1; wr_side = side; wr_idx = idx; wr_ebase = ebase_addr[31:17];
    wr_pbase = pbase_addr[31:17]; wr_mask = m; wr_vs = vs; wr_vu = vu; wr_attr = at;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string req, input logic [31:0] ea, input logic dside,
                      input logic sup, input logic ph, input logic [31:0] ppa,
                      input logic [2:0] pat, input logic [31:0] exp_pa,
                      input logic [1:0] exp_src, input logic [2:0] exp_attr);
    @(negedge clk);
    lk_ea = ea; lk_is_data = dside; lk_super = sup; pg_hit = ph; pg_pa = ppa; pg_attr = pat;
    #1;
    n_run++;
    if (pa !== exp_pa || src !== exp_src || attr !== exp_attr ||
        hit !== (exp_src != 2'b00) || miss !== (exp_src == 2'b00)) begin
      n_fail++;
      $display("FAIL %s ea=%h: pa=%h src=%b attr=%b hit=%b miss=%b expected pa=%h src=%b attr=%b",
               req, ea, pa, src, attr, hit, miss, exp_pa, exp_src, exp_attr);
    end
  endtask

  task automatic t_reset;  // R1, R9
    look("R1", 32'h1234_5678, 0, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
    look("R1", 32'h1234_5678, 1, 0, 0, 0, 0, 32'h0, 2'b00, 3'b000);
  endtask

  task automatic t_small_block;  // R2, R10
    put(0, 1, 32'h1234_0000, 32'h0400_0000, 11'h000, 1, 1, 3'b101);
    look("R2", 32'h1234_5678, 0, 1, 0, 0, 0, 32'h0400_5678, 2'b01, 3'b101);
    look("R10", 32'h1235_FFFF, 0, 0, 0, 0, 0, 32'h0401_FFFF, 2'b01, 3'b101);
    look("R2", 32'h1236_0000, 0, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
  endtask

  task automatic t_large_block;  // R3
    put(1, 0, 32'h3000_0000, 32'h5000_0000, 11'h7FF, 1, 1, 3'b010);
    look("R3", 32'h3ABC_DEF0, 1, 1, 0, 0, 0, 32'h5ABC_DEF0, 2'b01, 3'b010);
    look("R3", 32'h4000_0000, 1, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
    put(1, 1, 32'h8000_0000, 32'hC000_0000, 11'h00F, 1, 1, 3'b001);
    look("R3", 32'h801F_0004, 1, 1, 0, 0, 0, 32'hC01F_0004, 2'b01, 3'b001);
    look("R3", 32'h8020_0000, 1, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
  endtask

  task automatic t_privilege;  // R4
    put(1, 2, 32'h6000_0000, 32'h7000_0000, 11'h000, 1, 0, 3'b100);
    look("R4", 32'h6000_0100, 1, 0, 0, 0, 0, 32'h0, 2'b00, 3'b000);
    look("R4", 32'h6000_0100, 1, 1, 0, 0, 0, 32'h7000_0100, 2'b01, 3'b100);
    put(1, 2, 32'h6000_0000, 32'h7000_0000, 11'h000, 0, 1, 3'b100);
    look("R4", 32'h6000_0100, 1, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
    look("R4", 32'h6000_0100, 1, 0, 0, 0, 0, 32'h7000_0100, 2'b01, 3'b100);
  endtask

  task automatic t_sides;  // R5
    look("R5", 32'h3ABC_DEF0, 0, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
    look("R5", 32'h1234_5678, 1, 1, 0, 0, 0, 32'h0, 2'b00, 3'b000);
  endtask

  task automatic t_priority;  // R6
    put(1, 3, 32'h3000_0000, 32'h9000_0000, 11'h000, 1, 1, 3'b111);
    look("R6", 32'h3000_0010, 1, 1, 0, 0, 0, 32'h5000_0010, 2'b01, 3'b010);
    put(1, 0, 32'h3000_0000, 32'h5000_0000, 11'h7FF, 0, 0, 3'b010);
    look("R6", 32'h3000_0010, 1, 1, 0, 0, 0, 32'h9000_0010, 2'b01, 3'b111);
  endtask

  task automatic t_merge;  // R7, R8, R9
    look("R7", 32'h1234_5678, 0, 1, 1, 32'hDEAD_B000, 3'b011, 32'h0400_5678, 2'b01, 3'b101);
    look("R8", 32'hAAAA_0000, 0, 1, 1, 32'hDEAD_B000, 3'b011, 32'hDEAD_B000, 2'b10, 3'b011);
    look("R9", 32'hAAAA_0000, 0, 1, 0, 32'hDEAD_B000, 3'b011, 32'h0, 2'b00, 3'b000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset(); t_small_block(); t_large_block(); t_privilege();
        t_sides(); t_priority(); t_merge();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule